// File: doc/BRIEF.md
# Chained DMA Channel Sequencer

This block runs one DMA channel that reads 128-bit quadwords from memory and hands them out one 32-bit word at a time to a downstream command decoder. It has two ways to run. In direct mode it sends a fixed number of quadwords from a start address. In linked mode it walks a list of 128-bit descriptors, and each descriptor names the next packet's location and length. When tag forwarding is enabled, the upper half of every descriptor goes to the consumer ahead of the packet it describes.

The consumer can request an interrupt on any word it receives. That word is the last one delivered, and the channel then pauses and raises a stall flag. While paused, the address and count cover only whole quadwords that have been consumed, and the word position inside the partly used quadword is saved as an offset. A resume pulse continues from exactly the next word. A drop pulse abandons the transfer without signalling completion.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the channel is idle: `busy`=0, `fill_level`=0, `out_valid`=0, `done_irq`=0, `stall_irq`=0.
- R2: A `cfg_go` pulse while idle sets `busy`=1, and `fill_level` reads 8 for as long as `busy` is 1.
- R3: Direct mode is chosen when `cfg_chain`=0 or `cfg_count`≠0. It sends `cfg_count` quadwords from `cfg_addr` upward in steps of 16 bytes, each as 4 words with bits [31:0] first. No descriptor is read, and a count of 0 sends nothing.
- R4: At completion `busy` and `fill_level` return to 0, and `done_irq` pulses high for exactly one cycle.
- R5: Linked mode reads a descriptor at `cfg_tag_addr`. Word 0 bits [15:0] hold the quadword count, bits [30:28] the kind, and bit 31 the interrupt flag. Word 1 is a pointer. Kind 1 puts data just after the descriptor, with the next descriptor just after the data. Kind 2 puts data just after the descriptor, with the next descriptor at the pointer. Kind 3 puts data at the pointer, with the next descriptor just after the current one.
- R6: With `cfg_tag_fwd`=1, descriptor words 2 then 3 are sent with `out_is_tag`=1 before that descriptor's packet. With `cfg_tag_fwd`=0 no descriptor word is sent.
- R7: With `cfg_tag_irq_en`=1, a descriptor whose interrupt flag is set ends the list after its packet. With `cfg_tag_irq_en`=0 the flag has no effect.
- R8: Kind 0 sends its packet (data just after the descriptor) and then ends the list. Kinds 4 to 7 end the list at once and send no packet.
- R9: A word presented while `cons_irq_req`=1 is the last word delivered. The channel then holds `stall_irq`=1 with no output. `cur_addr` has advanced 16 bytes and `cur_count` has dropped by 1 for each whole quadword consumed, and `cur_offset` holds the number of words consumed mod 4.
- R10: A `rsm_go` pulse while paused continues with the word at the saved offset, so the delivered sequence is the same as it would be without a stall. This includes a stall inside a forwarded descriptor.
- R11: A `rsm_drop` pulse while paused clears `busy`, `fill_level` and `stall_irq` without a `done_irq` pulse.
- R12: While `dma_en`=0, linked mode issues no descriptor read and sends nothing, and `busy` stays 1. Progress resumes when `dma_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_go | input | 1 | Start pulse, taken only while idle |
| cfg_chain | input | 1 | Linked-mode select |
| cfg_tag_fwd | input | 1 | Forward descriptor upper half to the consumer |
| cfg_tag_irq_en | input | 1 | Honour the descriptor interrupt flag |
| cfg_addr | input | ADDR_W | Direct-mode start byte address |
| cfg_count | input | CNT_W | Direct-mode quadword count |
| cfg_tag_addr | input | ADDR_W | First descriptor byte address |
| dma_en | input | 1 | Global enable for linked-mode progress |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rd_data | input | QW_WORDS*WORD_W | Read data, valid one cycle after the request |
| out_valid | output | 1 | A word is presented to the consumer |
| out_word | output | WORD_W | Word presented to the consumer |
| out_is_tag | output | 1 | The word comes from a descriptor |
| cons_irq_req | input | 1 | Consumer interrupt request on the presented word |
| rsm_go | input | 1 | Resume pulse while paused |
| rsm_drop | input | 1 | Abandon pulse while paused |
| busy | output | 1 | Channel running (start bit) |
| fill_level | output | FILL_W | Queue-fill indicator |
| done_irq | output | 1 | Completion interrupt pulse |
| stall_irq | output | 1 | Paused on a consumer interrupt |
| cur_addr | output | ADDR_W | Current packet byte address |
| cur_count | output | CNT_W | Quadwords left in the current packet |
| cur_offset | output | $clog2(QW_WORDS) | Saved word offset |

## Verification
The embedded assertions watch properties that hold on every cycle. These are the coupling between `busy` and `fill_level`, the single-cycle completion pulse that coincides with `busy` falling, silence of both ports during a pause, the absence of descriptor reads while the global enable is low, the one-cycle spacing between read request and capture, and the rule that forwarded descriptor words come only from the upper half. Word ordering, the address, count and offset arithmetic at every stall position, descriptor-list walking by kind, interrupt-flag termination and seamless resumption inside a descriptor can only be shown by the bench's scenarios. The bench checks them against sequences it computes from its own memory image.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

   typedef enum logic [2:0] {
      KIND_END  = 3'd0,
      KIND_CNT  = 3'd1,
      KIND_NEXT = 3'd2,
      KIND_REF  = 3'd3
   } dcs_kind_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DREQ,
      ST_DCAP,
      ST_DOUT,
      ST_TREQ,
      ST_TCAP,
      ST_TOUT,
      ST_TAPPLY,
      ST_PKTEND,
      ST_PAUSE,
      ST_FINISH
   } dcs_state_e;

   typedef enum logic [1:0] {
      RS_DATA,
      RS_TAG,
      RS_APPLY
   } dcs_resume_e;

   localparam int KIND_LSB = 28;
   localparam int IRQ_BIT  = 31;

endpackage

// File: rtl/dcs_word_pick.sv
module dcs_word_pick #(
   parameter int WORD_W   = 32,
   parameter int QW_WORDS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [QW_WORDS*WORD_W-1:0]    qw_in,
   input  logic [$clog2(QW_WORDS)-1:0]   idx,
   output logic [QW_WORDS*WORD_W-1:0]    qw_q,
   output logic [WORD_W-1:0]             word_out
);
   localparam int QW_W = QW_WORDS * WORD_W;

   logic [QW_W-1:0]   buf_q;
   logic [WORD_W-1:0] lane [QW_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    buf_q <= '0;
      else if (load) buf_q <= qw_in;
   end

   generate
      for (genvar g = 0; g < QW_WORDS; g++) begin : g_lane
         assign lane[g] = buf_q[g*WORD_W +: WORD_W];
      end
   endgenerate

   assign word_out = lane[idx];
   assign qw_q     = buf_q;
endmodule

// File: rtl/dcs_tag_decode.sv
module dcs_tag_decode import dcs_pkg::*; #(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 16,
   parameter int QW_BYTES = 16
) (
   input  logic [ADDR_W-1:0] tag_at,
   input  logic [2:0]        tag_kind,
   input  logic              tag_irq,
   input  logic [CNT_W-1:0]  tag_count,
   input  logic [ADDR_W-1:0] tag_ptr,
   input  logic              irq_en,
   output logic [ADDR_W-1:0] pkt_addr,
   output logic [CNT_W-1:0]  pkt_count,
   output logic [ADDR_W-1:0] next_at,
   output logic              last_pkt,
   output logic              bad_kind
);
   localparam int QW_SHIFT = $clog2(QW_BYTES);

   logic [ADDR_W-1:0] after_tag;
   logic [ADDR_W-1:0] span;

   assign after_tag = tag_at + ADDR_W'(QW_BYTES);
   assign span      = ADDR_W'(tag_count) << QW_SHIFT;
   assign pkt_count = tag_count;

   always_comb begin
      pkt_addr = after_tag;
      next_at  = after_tag;
      last_pkt = irq_en & tag_irq;
      bad_kind = 1'b0;
      case (dcs_kind_e'(tag_kind))
         KIND_END:  last_pkt = 1'b1;
         KIND_CNT:  next_at  = after_tag + span;
         KIND_NEXT: next_at  = tag_ptr;
         KIND_REF:  pkt_addr = tag_ptr;
         default:   bad_kind = 1'b1;
      endcase
   end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq import dcs_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int WORD_W     = 32,
   parameter int QW_WORDS   = 4,
   parameter int FILL_W     = 4,
   parameter int FILL_START = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_go,
   input  logic                          cfg_chain,
   input  logic                          cfg_tag_fwd,
   input  logic                          cfg_tag_irq_en,
   input  logic [ADDR_W-1:0]             cfg_addr,
   input  logic [CNT_W-1:0]              cfg_count,
   input  logic [ADDR_W-1:0]             cfg_tag_addr,
   input  logic                          dma_en,
   output logic                          mem_rd_en,
   output logic [ADDR_W-1:0]             mem_rd_addr,
   input  logic [QW_WORDS*WORD_W-1:0]    mem_rd_data,
   output logic                          out_valid,
   output logic [WORD_W-1:0]             out_word,
   output logic                          out_is_tag,
   input  logic                          cons_irq_req,
   input  logic                          rsm_go,
   input  logic                          rsm_drop,
   output logic                          busy,
   output logic [FILL_W-1:0]             fill_level,
   output logic                          done_irq,
   output logic                          stall_irq,
   output logic [ADDR_W-1:0]             cur_addr,
   output logic [CNT_W-1:0]              cur_count,
   output logic [$clog2(QW_WORDS)-1:0]   cur_offset
);
   localparam int QW_W     = QW_WORDS * WORD_W;
   localparam int OFF_W    = $clog2(QW_WORDS);
   localparam int QW_BYTES = QW_W / 8;
   localparam int HALF     = QW_WORDS / 2;
   localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(QW_WORDS - 1);
   localparam logic [OFF_W-1:0] HALF_IDX = OFF_W'(HALF);

   generate
      if (QW_WORDS < 4 || (QW_WORDS & (QW_WORDS - 1)) != 0) begin : g_bad_words
         $error("QW_WORDS must be a power of two of at least 4");
      end
      if (WORD_W < 32 || ADDR_W > WORD_W) begin : g_bad_word_w
         $error("WORD_W must be at least 32 and hold an address");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16");
      end
      if (FILL_START >= (1 << FILL_W)) begin : g_bad_fill
         $error("FILL_START does not fit FILL_W");
      end
   endgenerate

   dcs_state_e        state_q;
   dcs_resume_e       rsm_q;
   logic              busy_q, done_q, chain_q, fwd_q, tie_q, last_q;
   logic [FILL_W-1:0] fill_q;
   logic [ADDR_W-1:0] addr_q, tadr_q;
   logic [CNT_W-1:0]  count_q;
   logic [OFF_W-1:0]  off_q, idx_q;

   logic [QW_W-1:0]   buf_qw;
   logic [WORD_W-1:0] pick_word;
   logic              buf_load;

   logic [ADDR_W-1:0] dec_addr, dec_next;
   logic [CNT_W-1:0]  dec_count;
   logic              dec_last, dec_bad;
   logic [WORD_W-1:0] tag_w0, tag_w1;
   logic              tag_unused;
   logic              last_word;

   assign buf_load = (state_q == ST_DCAP) || (state_q == ST_TCAP);

   dcs_word_pick #(
      .WORD_W   (WORD_W),
      .QW_WORDS (QW_WORDS)
   ) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (buf_load),
      .qw_in    (mem_rd_data),
      .idx      (idx_q),
      .qw_q     (buf_qw),
      .word_out (pick_word)
   );

   assign tag_w0     = buf_qw[WORD_W-1:0];
   assign tag_w1     = buf_qw[2*WORD_W-1:WORD_W];
   assign tag_unused = ^{buf_qw[QW_W-1:2*WORD_W], tag_w0[KIND_LSB-1:CNT_W], tag_w0, tag_w1};

   dcs_tag_decode #(
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W),
      .QW_BYTES (QW_BYTES)
   ) u_decode (
      .tag_at    (tadr_q),
      .tag_kind  (tag_w0[KIND_LSB +: 3]),
      .tag_irq   (tag_w0[IRQ_BIT]),
      .tag_count (tag_w0[CNT_W-1:0]),
      .tag_ptr   (tag_w1[ADDR_W-1:0]),
      .irq_en    (tie_q),
      .pkt_addr  (dec_addr),
      .pkt_count (dec_count),
      .next_at   (dec_next),
      .last_pkt  (dec_last),
      .bad_kind  (dec_bad)
   );

   assign last_word   = (idx_q == LAST_IDX);
   assign out_valid   = (state_q == ST_DOUT) || (state_q == ST_TOUT);
   assign out_is_tag  = (state_q == ST_TOUT);
   assign out_word    = out_valid ? pick_word : '0;
   assign mem_rd_en   = (state_q == ST_DREQ) || ((state_q == ST_TREQ) && dma_en);
   assign mem_rd_addr = (state_q == ST_TREQ) ? tadr_q : addr_q;
   assign busy        = busy_q;
   assign fill_level  = fill_q;
   assign done_irq    = done_q;
   assign stall_irq   = (state_q == ST_PAUSE);
   assign cur_addr    = addr_q;
   assign cur_count   = count_q;
   assign cur_offset  = off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rsm_q   <= RS_DATA;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         chain_q <= 1'b0;
         fwd_q   <= 1'b0;
         tie_q   <= 1'b0;
         last_q  <= 1'b0;
         fill_q  <= '0;
         addr_q  <= '0;
         tadr_q  <= '0;
         count_q <= '0;
         off_q   <= '0;
         idx_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (cfg_go) begin
                  busy_q  <= 1'b1;
                  fill_q  <= FILL_W'(FILL_START);
                  addr_q  <= cfg_addr;
                  count_q <= cfg_count;
                  tadr_q  <= cfg_tag_addr;
                  fwd_q   <= cfg_tag_fwd;
                  tie_q   <= cfg_tag_irq_en;
                  last_q  <= 1'b0;
                  if (!cfg_chain || cfg_count != '0) begin
                     chain_q <= 1'b0;
                     off_q   <= '0;
                     state_q <= (cfg_count != '0) ? ST_DREQ : ST_FINISH;
                  end else begin
                     chain_q <= 1'b1;
                     off_q   <= HALF_IDX;
                     state_q <= ST_TREQ;
                  end
               end
            end
            ST_DREQ: state_q <= ST_DCAP;
            ST_DCAP: begin
               idx_q   <= off_q;
               off_q   <= '0;
               state_q <= ST_DOUT;
            end
            ST_DOUT: begin
               if (last_word) begin
                  addr_q  <= addr_q + ADDR_W'(QW_BYTES);
                  count_q <= count_q - CNT_W'(1);
               end
               if (cons_irq_req) begin
                  off_q   <= last_word ? '0 : idx_q + OFF_W'(1);
                  rsm_q   <= RS_DATA;
                  state_q <= ST_PAUSE;
               end else if (last_word) begin
                  state_q <= (count_q == CNT_W'(1)) ? ST_PKTEND : ST_DREQ;
               end else begin
                  idx_q <= idx_q + OFF_W'(1);
               end
            end
            ST_TREQ: if (dma_en) state_q <= ST_TCAP;
            ST_TCAP: begin
               idx_q   <= off_q;
               off_q   <= '0;
               state_q <= fwd_q ? ST_TOUT : ST_TAPPLY;
            end
            ST_TOUT: begin
               if (cons_irq_req) begin
                  off_q   <= last_word ? '0 : idx_q + OFF_W'(1);
                  rsm_q   <= last_word ? RS_APPLY : RS_TAG;
                  state_q <= ST_PAUSE;
               end else if (last_word) begin
                  state_q <= ST_TAPPLY;
               end else begin
                  idx_q <= idx_q + OFF_W'(1);
               end
            end
            ST_TAPPLY: begin
               if (dec_bad) begin
                  state_q <= ST_FINISH;
               end else begin
                  addr_q  <= dec_addr;
                  count_q <= dec_count;
                  tadr_q  <= dec_next;
                  last_q  <= dec_last;
                  off_q   <= '0;
                  state_q <= (dec_count != '0) ? ST_DREQ : ST_PKTEND;
               end
            end
            ST_PKTEND: begin
               if (!chain_q || last_q) begin
                  state_q <= ST_FINISH;
               end else begin
                  off_q   <= HALF_IDX;
                  state_q <= ST_TREQ;
               end
            end
            ST_PAUSE: begin
               if (rsm_drop) begin
                  busy_q  <= 1'b0;
                  fill_q  <= '0;
                  state_q <= ST_IDLE;
               end else if (rsm_go) begin
                  case (rsm_q)
                     RS_TAG:   state_q <= ST_TREQ;
                     RS_APPLY: state_q <= ST_TAPPLY;
                     default:  state_q <= (count_q != '0) ? ST_DREQ : ST_PKTEND;
                  endcase
               end
            end
            ST_FINISH: begin
               busy_q  <= 1'b0;
               fill_q  <= '0;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_fill_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (fill_q == FILL_W'(FILL_START)));

   assert_fill_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (fill_q == '0));

   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   assert_done_with_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);

   assert_pause_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stall_irq |-> (!out_valid && !mem_rd_en));

   assert_hold_no_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TREQ && !dma_en) |=> (state_q == ST_TREQ));

   assert_tag_upper_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_is_tag |-> (idx_q >= HALF_IDX));

   assert_capture_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      buf_load |-> $past(mem_rd_en));

endmodule

// File: tb/dma_chain_seq_bench.sv
module dma_chain_seq_bench;
   localparam int ADDR_W = 32;
   localparam int CNT_W  = 16;
   localparam int WORD_W = 32;
   localparam int QW_WORDS = 4;
   localparam int FILL_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_go = 1'b0, cfg_chain = 1'b0, cfg_tag_fwd = 1'b0, cfg_tag_irq_en = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0, cfg_tag_addr = '0;
   logic [CNT_W-1:0]  cfg_count = '0;
   logic dma_en = 1'b1;
   logic mem_rd_en;
   logic [ADDR_W-1:0] mem_rd_addr;
   logic [127:0] mem_rd_data = '0;
   logic out_valid, out_is_tag;
   logic [WORD_W-1:0] out_word;
   logic cons_irq_req = 1'b0, rsm_go = 1'b0, rsm_drop = 1'b0;
   logic busy, done_irq, stall_irq;
   logic [FILL_W-1:0] fill_level;
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  cur_count;
   logic [1:0]        cur_offset;

   always #4 clk = ~clk;

   dma_chain_seq u_dma_chain_seq (
      .clk(clk), .rst_n(rst_n), .cfg_go(cfg_go), .cfg_chain(cfg_chain),
      .cfg_tag_fwd(cfg_tag_fwd), .cfg_tag_irq_en(cfg_tag_irq_en),
      .cfg_addr(cfg_addr), .cfg_count(cfg_count), .cfg_tag_addr(cfg_tag_addr),
      .dma_en(dma_en), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_word(out_word),
      .out_is_tag(out_is_tag), .cons_irq_req(cons_irq_req), .rsm_go(rsm_go),
      .rsm_drop(rsm_drop), .busy(busy), .fill_level(fill_level),
      .done_irq(done_irq), .stall_irq(stall_irq), .cur_addr(cur_addr),
      .cur_count(cur_count), .cur_offset(cur_offset)
   );

   logic [127:0] mem [0:63];
   always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:4]];

   int tests = 0, fails = 0;
   int exp_n = 0, got_n = 0, stall_at = -1, done_cnt = 0;
   logic [31:0] exp_w [0:511];
   logic        exp_t [0:511];
   string cur_req = "R3";

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put_tag(input int at, input int kind, input int irq, input int qwc, input int ptr);
      logic [31:0] w0;
      w0 = {irq[0], kind[2:0], 12'h000, qwc[15:0]};
      mem[at >> 4] = {32'hB000_0000 + 32'(at), 32'hA000_0000 + 32'(at), 32'(ptr), w0};
   endtask

   task automatic push_qw(input int at, input int from);
      for (int j = from; j < 4; j++) begin
         exp_w[exp_n] = mem[at >> 4][j*32 +: 32];
         exp_t[exp_n] = 1'b0;
         exp_n++;
      end
   endtask

   task automatic push_tag(input int at);
      for (int j = 2; j < 4; j++) begin
         exp_w[exp_n] = mem[at >> 4][j*32 +: 32];
         exp_t[exp_n] = 1'b1;
         exp_n++;
      end
   endtask

   task automatic clear_exp();
      exp_n = 0; got_n = 0; stall_at = -1;
   endtask

   // consumer monitor: compares every presented word, raises the interrupt request on demand
   initial begin
      forever begin
         @(negedge clk);
         cons_irq_req = 1'b0;
         if (done_irq) done_cnt++;
         if (out_valid) begin
            if (got_n < exp_n)
               check(out_word == exp_w[got_n] && out_is_tag == exp_t[got_n], cur_req,
                     "word", {out_is_tag, out_word}, {exp_t[got_n], exp_w[got_n]});
            else
               check(1'b0, cur_req, "extra word", out_word, 0);
            got_n++;
            if (got_n == stall_at) cons_irq_req = 1'b1;
         end
      end
   end

   task automatic start(input bit ch, input bit fwd, input bit tie,
                        input int addr, input int cnt, input int tadr);
      @(negedge clk);
      cfg_chain = ch; cfg_tag_fwd = fwd; cfg_tag_irq_en = tie;
      cfg_addr = 32'(addr); cfg_count = 16'(cnt); cfg_tag_addr = 32'(tadr);
      cfg_go = 1'b1;
      @(negedge clk);
      cfg_go = 1'b0;
      check(busy == 1'b1 && fill_level == 4'd8, "R2", "busy/fill at start", {busy, fill_level}, 5'h18);
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 3000) begin @(negedge clk); n++; end
      check(!busy, cur_req, "finished", busy, 0);
   endtask

   task automatic wait_pause();
      int n = 0;
      while (!stall_irq && n < 3000) begin @(negedge clk); n++; end
      check(stall_irq, "R9", "paused", stall_irq, 1);
   endtask

   task automatic pulse_resume();
      @(negedge clk); rsm_go = 1'b1;
      @(negedge clk); rsm_go = 1'b0;
   endtask

   task automatic finish_checks(input string req, input int d0);
      check(got_n == exp_n, req, "word count", got_n, exp_n);
      check(done_cnt == d0 + 1, "R4", "one done pulse", done_cnt - d0, 1);
      check(fill_level == 4'd0, "R4", "fill cleared", fill_level, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int d0;
      for (int i = 0; i < 64; i++)
         for (int j = 0; j < 4; j++)
            mem[i][j*32 +: 32] = 32'h5000_0000 + 32'(i * 4 + j);
      put_tag(32'h200, 1, 0, 2, 32'h0);      // cnt: data at 0x210, next at 0x230
      put_tag(32'h230, 3, 1, 1, 32'h080);    // ref with irq flag: data at 0x080, next at 0x240
      put_tag(32'h240, 2, 0, 1, 32'h300);    // next: data at 0x250, next at 0x300
      put_tag(32'h300, 0, 0, 1, 32'h0);      // end: data at 0x310
      put_tag(32'h380, 5, 0, 2, 32'h0);      // unknown kind

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && fill_level == 0 && !out_valid && !done_irq && !stall_irq, "R1",
            "reset state", {busy, fill_level, out_valid, done_irq, stall_irq}, 0);

      // R3 direct mode, count sweep
      for (int c = 1; c <= 4; c++) begin
         clear_exp(); cur_req = "R3";
         for (int q = 0; q < c; q++) push_qw(32'h40 + q * 16, 0);
         d0 = done_cnt;
         start(0, 0, 0, 32'h40, c, 32'h0);
         wait_idle(); @(negedge clk);
         finish_checks("R3", d0);
      end

      // R3 linked flag with a non-zero count still runs direct, no descriptor words
      clear_exp(); cur_req = "R3";
      push_qw(32'h100, 0);
      d0 = done_cnt;
      start(1, 1, 0, 32'h100, 1, 32'h200);
      wait_idle(); @(negedge clk);
      finish_checks("R3", d0);

      // R3 zero count sends nothing
      clear_exp(); cur_req = "R3";
      d0 = done_cnt;
      start(0, 0, 0, 32'h40, 0, 32'h0);
      wait_idle(); @(negedge clk);
      finish_checks("R3", d0);

      // R9/R10 stall sweep across every word position
      for (int s = 1; s <= 12; s++) begin
         clear_exp(); cur_req = "R10";
         for (int q = 0; q < 3; q++) push_qw(32'h40 + q * 16, 0);
         stall_at = s;
         d0 = done_cnt;
         start(0, 0, 0, 32'h40, 3, 32'h0);
         wait_pause();
         check(got_n == s, "R9", "words before pause", got_n, s);
         check(cur_addr == 32'(32'h40 + 16 * (s / 4)), "R9", "paused address", cur_addr, 32'h40 + 16 * (s / 4));
         check(cur_count == 16'(3 - s / 4), "R9", "paused count", cur_count, 3 - s / 4);
         check(cur_offset == 2'(s % 4), "R9", "paused offset", cur_offset, s % 4);
         repeat (3) @(negedge clk);
         check(!out_valid && stall_irq && got_n == s, "R9", "quiet while paused", got_n, s);
         pulse_resume();
         wait_idle(); @(negedge clk);
         finish_checks("R10", d0);
      end

      // R5/R6/R8 full list with descriptor forwarding, irq flag ignored
      clear_exp(); cur_req = "R5";
      push_tag(32'h200); push_qw(32'h210, 0); push_qw(32'h220, 0);
      push_tag(32'h230); push_qw(32'h080, 0);
      push_tag(32'h240); push_qw(32'h250, 0);
      push_tag(32'h300); push_qw(32'h310, 0);
      d0 = done_cnt;
      start(1, 1, 0, 32'h0, 0, 32'h200);
      wait_idle(); @(negedge clk);
      finish_checks("R6", d0);

      // R7 irq flag honoured, no forwarding
      clear_exp(); cur_req = "R7";
      push_qw(32'h210, 0); push_qw(32'h220, 0); push_qw(32'h080, 0);
      d0 = done_cnt;
      start(1, 0, 1, 32'h0, 0, 32'h200);
      wait_idle(); @(negedge clk);
      finish_checks("R7", d0);

      // R8 unknown kind ends with no packet
      clear_exp(); cur_req = "R8";
      d0 = done_cnt;
      start(1, 1, 0, 32'h0, 0, 32'h380);
      clear_exp();
      push_tag(32'h380);
      wait_idle(); @(negedge clk);
      finish_checks("R8", d0);

      // R12 global enable holds the list walk
      clear_exp(); cur_req = "R12";
      push_qw(32'h310, 0);
      dma_en = 1'b0;
      d0 = done_cnt;
      start(1, 0, 0, 32'h0, 0, 32'h300);
      repeat (30) @(negedge clk);
      check(busy && got_n == 0 && done_cnt == d0, "R12", "held while disabled", got_n, 0);
      dma_en = 1'b1;
      wait_idle(); @(negedge clk);
      finish_checks("R12", d0);

      // R10 stall inside a forwarded descriptor
      clear_exp(); cur_req = "R10";
      push_tag(32'h300); push_qw(32'h310, 0);
      stall_at = 1;
      d0 = done_cnt;
      start(1, 1, 0, 32'h0, 0, 32'h300);
      wait_pause();
      check(cur_offset == 2'd3, "R10", "offset inside descriptor", cur_offset, 3);
      pulse_resume();
      wait_idle(); @(negedge clk);
      finish_checks("R10", d0);

      // R11 abandon while paused
      clear_exp(); cur_req = "R11";
      push_qw(32'h40, 0); push_qw(32'h50, 0);
      stall_at = 2;
      d0 = done_cnt;
      start(0, 0, 0, 32'h40, 2, 32'h0);
      wait_pause();
      @(negedge clk); rsm_drop = 1'b1;
      @(negedge clk); rsm_drop = 1'b0;
      repeat (4) @(negedge clk);
      check(!busy && fill_level == 0 && !stall_irq, "R11", "dropped state",
            {busy, fill_level, stall_irq}, 0);
      check(done_cnt == d0 && got_n == 2, "R11", "no done, no words", done_cnt - d0, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule